// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave. Through it, a host controller reads and writes a memory-mapped space of RAMs and registers that sits behind a simple internal bus. The host lowers a frame-select line and clocks in a header of three bytes. The first is a chip identifier with a direction flag, and the next two carry a 12-bit subaddress. The host then streams data bytes, most significant bit first. Every incoming line is brought into the system clock domain with a two-flop synchronizer. The serial clock is then oversampled, and its edges are detected on the synchronized copy.

The number of bytes in a data word depends on the region the current address falls in. After each complete word the block raises a one-cycle write strobe, or prefetches the next read word, and moves to the next address. A single header can therefore open a burst that spans many consecutive locations. On reads, the serial output is enabled only from the first data byte onward. It goes back to high impedance when the frame ends.

Top module: `spi_regslv`

## Requirements
- R1: Byte 0 bits 7:1 must equal 000000 followed by the `chip_sel` pin value. Otherwise the whole frame is ignored: no bus strobe is raised and `spi_miso_oe` stays low.
- R2: Serial input is sampled on rising `spi_sclk` edges, MSB first. Bit 0 of byte 0 is the direction flag, with 1 for read and 0 for write. Byte 1 bits 3:0 are subaddress bits 11:8, and its upper nibble is ignored. Byte 2 holds subaddress bits 7:0.
- R3: The data word length in bytes is decided by the current subaddress. It is 4 for 0x000–0x3FF, 5 for 0x400–0x9FF and 5 for 0xA00–0xA44. It is 2 for 0xA45–0xA49 and 2 for 0xA50–0xA51. For 0xA4A–0xA4F it is 2 on writes and 3 on reads. Every other address uses 1 byte.
- R4: After the last bit of a write word, `bus_we` pulses for one cycle with `bus_addr` set to the word's address. `bus_wdata` carries the word right-aligned, with the first byte received as the most significant byte.
- R5: In a burst, each further word goes to the previous subaddress plus one, and its length is decoded again for the new address.
- R6: A write word still incomplete when `spi_csn` rises produces no strobe and is discarded.
- R7: Read data is placed on `spi_miso` after falling `spi_sclk` edges, MSB first. The bytes are the low word-length bytes of `bus_rdata`. `bus_rdata` is taken one cycle after the `bus_re` pulse.
- R8: `spi_miso_oe` is low through the three header bytes and high from the first data byte of a read. It goes low again once `spi_csn` is high.
- R9: During and right after reset, `bus_we`, `bus_re` and `spi_miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Selects which of two chip identifiers this slave answers |
| spi_csn | input | 1 | Frame select, low during a transaction |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial readback data |
| spi_miso_oe | output | 1 | Output enable for the readback pad driver |
| bus_addr | output | 12 | Internal bus address |
| bus_wdata | output | 40 | Internal bus write data, right-aligned |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read request |
| bus_rdata | input | 40 | Read data, valid one cycle after `bus_re` |

## Verification
The hardest case to reach is a read burst that crosses a word boundary. There, the word for the next address must already be fetched over the bus and loaded into the shifter on the one falling edge that follows the last bit of the previous word. A word too early or too late shows up only as shifted bytes. The bench drives long read bursts into the 5-byte program region and into the 3-byte capture region. It checks every returned byte against an address-derived pattern that the bench model of the bus returns. It also samples the output enable at the first bit of each byte, so a late or early enable is seen at the byte 2/byte 3 boundary.

// File: rtl/spi_regslv_pkg.sv
package spi_regslv_pkg;
  localparam int ADDR_W    = 12;
  localparam int MAX_BYTES = 5;
  localparam int DATA_W    = MAX_BYTES * 8;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  // Upper bounds of the ordered address regions
  localparam logic [ADDR_W-1:0] COEF_TOP  = 12'h3FF;
  localparam logic [ADDR_W-1:0] CODE_TOP  = 12'h9FF;
  localparam logic [ADDR_W-1:0] WIDE_TOP  = 12'hA44;
  localparam logic [ADDR_W-1:0] PTR_TOP   = 12'hA49;
  localparam logic [ADDR_W-1:0] PROBE_TOP = 12'hA4F;
  localparam logic [ADDR_W-1:0] CFG2_TOP  = 12'hA51;

  typedef enum logic [1:0] {
    FR_HEAD = 2'd0,
    FR_DATA = 2'd1,
    FR_SKIP = 2'd2
  } frame_st_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_len_decode.sv
module spi_len_decode
  import spi_regslv_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  output logic [LW-1:0] nbytes
);
  always_comb begin
    if (addr <= COEF_TOP)       nbytes = LW'(4);
    else if (addr <= CODE_TOP)  nbytes = LW'(5);
    else if (addr <= WIDE_TOP)  nbytes = LW'(5);
    else if (addr <= PTR_TOP)   nbytes = LW'(2);
    else if (addr <= PROBE_TOP) nbytes = rd ? LW'(3) : LW'(2);
    else if (addr <= CFG2_TOP)  nbytes = LW'(2);
    else                        nbytes = LW'(1);
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int MAXB = 5,
  parameter int DW   = MAXB * 8,
  parameter int LW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] word,
  input  logic [LW-1:0] nbytes,
  output logic          miso,
  output logic          oe
);
  logic [DW-1:0]   sreg;
  logic [LW+2:0]   shamt;
  logic [LW-1:0]   pad;

  assign pad   = LW'(MAXB) - nbytes;
  assign shamt = {pad, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      oe   <= 1'b0;
    end else if (idle) begin
      oe <= 1'b0;
    end else if (load) begin
      sreg <= word << shamt;
      oe   <= 1'b1;
    end else if (shift) begin
      sreg <= {sreg[DW-2:0], 1'b0};
    end
  end

  assign miso = sreg[DW-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regslv_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          chip_sel,
  input  logic [LW-1:0] word_len,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] cur_addr,
  output logic          rd_mode,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  output logic          tx_load,
  output logic          tx_shift,
  output logic [DW-1:0] tx_word
);
  frame_st_t     st;
  logic          sclk_q;
  logic          rise, fall;
  logic [2:0]    bit_cnt;
  logic [1:0]    hdr_idx;
  logic [7:0]    byte_sh;
  logic [7:0]    nb;
  logic [LW-1:0] wcnt;
  logic [DW-1:0] wsh, wsh_nx;
  logic          fresh;
  logic          re_d;
  logic [DW-1:0] rbuf;
  logic [AW-1:0] addr;
  logic          rd;
  logic          byte_done, word_done, id_ok;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign nb        = {byte_sh[6:0], mosi_s};
  assign wsh_nx    = {wsh[DW-2:0], mosi_s};
  assign byte_done = (bit_cnt == 3'd7);
  assign word_done = byte_done && (wcnt == word_len - LW'(1));
  assign id_ok     = (nb[7:1] == {6'b000000, chip_sel});

  assign tx_load  = fall && !csn_s && (st == FR_DATA) && rd && fresh;
  assign tx_shift = fall && !csn_s && (st == FR_DATA) && rd && !fresh;
  assign tx_word  = rbuf;
  assign cur_addr = addr;
  assign rd_mode  = rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FR_HEAD;
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      hdr_idx   <= '0;
      byte_sh   <= '0;
      wcnt      <= '0;
      wsh       <= '0;
      fresh     <= 1'b0;
      re_d      <= 1'b0;
      rbuf      <= '0;
      addr      <= '0;
      rd        <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      sclk_q <= sclk_s;
      re_d   <= bus_re;
      if (re_d) rbuf <= bus_rdata;

      if (csn_s) begin
        st      <= FR_HEAD;
        bit_cnt <= '0;
        hdr_idx <= '0;
        wcnt    <= '0;
        wsh     <= '0;
        fresh   <= 1'b0;
        rd      <= 1'b0;
      end else if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        case (st)
          FR_HEAD: begin
            byte_sh <= nb;
            if (byte_done) begin
              case (hdr_idx)
                2'd0: begin
                  if (id_ok) begin
                    rd      <= nb[0];
                    hdr_idx <= 2'd1;
                  end else begin
                    st <= FR_SKIP;
                  end
                end
                2'd1: begin
                  addr[AW-1:8] <= nb[AW-9:0];
                  hdr_idx      <= 2'd2;
                end
                default: begin
                  addr[7:0] <= nb;
                  st        <= FR_DATA;
                  fresh     <= 1'b1;
                  wcnt      <= '0;
                  wsh       <= '0;
                  if (rd) begin
                    bus_re   <= 1'b1;
                    bus_addr <= {addr[AW-1:8], nb};
                  end
                end
              endcase
            end
          end
          FR_DATA: begin
            fresh <= 1'b0;
            wsh   <= wsh_nx;
            if (word_done) begin
              wcnt  <= '0;
              fresh <= 1'b1;
              wsh   <= '0;
              addr  <= addr + AW'(1);
              if (rd) begin
                bus_re   <= 1'b1;
                bus_addr <= addr + AW'(1);
              end else begin
                bus_we    <= 1'b1;
                bus_addr  <= addr;
                bus_wdata <= wsh_nx;
              end
            end else if (byte_done) begin
              wcnt <= wcnt + LW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regslv.sv
module spi_regslv
  import spi_regslv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW          = ADDR_W,
  parameter int MAXB        = MAX_BYTES,
  parameter int DW          = MAXB * 8,
  parameter int LW          = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel,
  input  logic          spi_csn,
  input  logic          spi_sclk,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata
);
  logic [2:0]    sync_q;
  logic          csn_s, sclk_s, mosi_s;
  logic [AW-1:0] cur_addr;
  logic          rd_mode;
  logic [LW-1:0] word_len;
  logic          tx_load, tx_shift;
  logic [DW-1:0] tx_word;

  spi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_csn, spi_sclk, spi_mosi}),
    .dout(sync_q)
  );
  assign {csn_s, sclk_s, mosi_s} = sync_q;

  spi_len_decode #(.AW(AW), .LW(LW)) u_len (
    .addr  (cur_addr),
    .rd    (rd_mode),
    .nbytes(word_len)
  );

  spi_frame_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .csn_s    (csn_s),
    .sclk_s   (sclk_s),
    .mosi_s   (mosi_s),
    .chip_sel (chip_sel),
    .word_len (word_len),
    .bus_rdata(bus_rdata),
    .cur_addr (cur_addr),
    .rd_mode  (rd_mode),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .tx_load  (tx_load),
    .tx_shift (tx_shift),
    .tx_word  (tx_word)
  );

  spi_tx_shift #(.MAXB(MAXB), .DW(DW), .LW(LW)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .idle  (csn_s),
    .load  (tx_load),
    .shift (tx_shift),
    .word  (tx_word),
    .nbytes(word_len),
    .miso  (spi_miso),
    .oe    (spi_miso_oe)
  );
endmodule

// File: rtl/spi_regslv_chk.sv
module spi_regslv_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          spi_csn,
  input logic          spi_miso_oe,
  input logic          bus_we,
  input logic          bus_re,
  input logic [AW-1:0] bus_addr
);
  logic [2:0]    hi_cnt;
  logic          seen;
  logic [AW-1:0] last_addr;
  logic          quiet;

  assign quiet = (hi_cnt >= 3'd5);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      seen      <= 1'b0;
      last_addr <= '0;
    end else begin
      if (!spi_csn)           hi_cnt <= '0;
      else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
      if (quiet) seen <= 1'b0;
      else if (bus_we || bus_re) begin
        seen      <= 1'b1;
        last_addr <= bus_addr;
      end
    end
  end

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (rst)
    quiet |-> !spi_miso_oe); // R8
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    quiet |-> !(bus_we || bus_re)); // R6
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we); // R4
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re)); // R2
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    ((bus_we || bus_re) && seen) |-> (bus_addr == last_addr + AW'(1))); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !(bus_we || bus_re || spi_miso_oe)); // R9
endmodule

bind spi_regslv spi_regslv_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .spi_csn    (spi_csn),
  .spi_miso_oe(spi_miso_oe),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr)
);

// File: tb/sim_spi_regslv.sv
module sim_spi_regslv;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip_sel = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic        spi_miso_oe;
  logic [11:0] bus_addr;
  logic [39:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [39:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  tx_buf [0:15];
  logic [7:0]  rx_buf [0:15];
  logic        oe_at  [0:15];
  logic        oe_end;
  logic [11:0] wa [0:63];
  logic [39:0] wd [0:63];
  int          wn = 0;
  int          rn = 0;

  always #2 clk = ~clk;

  spi_regslv u0 (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  function automatic logic [39:0] pat(input logic [11:0] a);
    return {a[3:0], a, ~a, a};
  endfunction

  always @(posedge clk) begin
    if (bus_re) bus_rdata <= pat(bus_addr);
    if (!rst && bus_we) begin
      wa[wn % 64] <= bus_addr;
      wd[wn % 64] <= bus_wdata;
      wn <= wn + 1;
    end
    if (!rst && bus_re) rn <= rn + 1;
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    spi_csn = 1'b0;
    wait_clks(HALF);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = tx_buf[i][b];
        wait_clks(HALF);
        rx_buf[i][b] = spi_miso;
        if (b == 7) oe_at[i] = spi_miso_oe;
        spi_sclk = 1'b1;
        wait_clks(HALF);
        spi_sclk = 1'b0;
      end
    end
    wait_clks(HALF);
    spi_csn = 1'b1;
    wait_clks(2 * HALF);
    oe_end = spi_miso_oe;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_clks(5);
    check("R9 we in reset", 64'(bus_we), 64'd0);
    check("R9 oe in reset", 64'(spi_miso_oe), 64'd0);
    rst = 1'b0;
    wait_clks(3);
    check("R9 re after reset", 64'(bus_re), 64'd0);
  endtask

  task automatic t_param_write;
    int base = wn;
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00; tx_buf[2] = 8'h12;
    tx_buf[3] = 8'h11; tx_buf[4] = 8'h22; tx_buf[5] = 8'h33; tx_buf[6] = 8'h44;
    run(7);
    check("R3 4-byte word strobe count", 64'(wn - base), 64'd1);
    check("R4 write addr", 64'(wa[base % 64]), 64'h012);
    check("R4 write data", 64'(wd[base % 64]), 64'h11223344);
  endtask

  task automatic t_prog_burst;
    int base = wn;
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h04; tx_buf[2] = 8'h00;
    for (int i = 0; i < 10; i++) tx_buf[3+i] = 8'(i + 1);
    run(13);
    check("R5 burst strobe count", 64'(wn - base), 64'd2);
    check("R5 burst addr0", 64'(wa[base % 64]), 64'h400);
    check("R5 burst addr1", 64'(wa[(base+1) % 64]), 64'h401);
    check("R3 5-byte data0", 64'(wd[base % 64]), 64'h0102030405);
    check("R3 5-byte data1", 64'(wd[(base+1) % 64]), 64'h060708090A);
  endtask

  task automatic t_partial;
    int base = wn;
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00; tx_buf[2] = 8'h20;
    for (int i = 0; i < 6; i++) tx_buf[3+i] = 8'hA0 + 8'(i);
    run(9);
    check("R6 partial word dropped", 64'(wn - base), 64'd1);
    check("R6 full word data", 64'(wd[base % 64]), 64'hA0A1A2A3);
  endtask

  task automatic t_nibble;
    int base = wn;
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h50; tx_buf[2] = 8'h07;
    tx_buf[3] = 8'hDE; tx_buf[4] = 8'hAD; tx_buf[5] = 8'hBE; tx_buf[6] = 8'hEF;
    run(7);
    check("R2 upper nibble ignored", 64'(wa[base % 64]), 64'h007);
  endtask

  task automatic t_foreign_chip;
    int base = wn;
    int rb = rn;
    chip_sel = 1'b0;
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h00; tx_buf[2] = 8'h01;
    tx_buf[3] = 8'h55; tx_buf[4] = 8'h66; tx_buf[5] = 8'h77; tx_buf[6] = 8'h88;
    run(7);
    check("R1 foreign write ignored", 64'(wn - base), 64'd0);
    tx_buf[0] = 8'h03;
    run(7);
    check("R1 foreign read no request", 64'(rn - rb), 64'd0);
    check("R1 foreign read oe", 64'(oe_at[3] | oe_at[5]), 64'd0);
  endtask

  task automatic t_sel_high;
    int base = wn;
    chip_sel = 1'b1;
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h0A; tx_buf[2] = 8'h50;
    tx_buf[3] = 8'hBE; tx_buf[4] = 8'hEF;
    run(5);
    check("R1 id 0 ignored when sel high", 64'(wn - base), 64'd0);
    tx_buf[0] = 8'h02;
    run(5);
    check("R3 2-byte control count", 64'(wn - base), 64'd1);
    check("R3 2-byte control data", 64'(wd[base % 64]), 64'hBEEF);
    chip_sel = 1'b0;
  endtask

  task automatic t_param_read;
    logic [39:0] e = pat(12'h005);
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h00; tx_buf[2] = 8'h05;
    for (int i = 3; i < 7; i++) tx_buf[i] = 8'h00;
    run(7);
    check("R8 oe low during header", 64'(oe_at[2]), 64'd0);
    check("R8 oe high at byte 3", 64'(oe_at[3]), 64'd1);
    check("R8 oe low after frame", 64'(oe_end), 64'd0);
    for (int k = 0; k < 4; k++)
      check("R7 param read byte", 64'(rx_buf[3+k]), 64'(e[(3-k)*8 +: 8]));
  endtask

  task automatic t_capture;
    int base = wn;
    logic [39:0] e = pat(12'hA4A);
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h0A; tx_buf[2] = 8'h4A;
    for (int i = 3; i < 9; i++) tx_buf[i] = 8'h00;
    run(9);
    for (int k = 0; k < 3; k++)
      check("R3 capture read 3 bytes", 64'(rx_buf[3+k]), 64'(e[(2-k)*8 +: 8]));
    e = pat(12'hA4B);
    for (int k = 0; k < 3; k++)
      check("R5 capture read next word", 64'(rx_buf[6+k]), 64'(e[(2-k)*8 +: 8]));
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h0A; tx_buf[2] = 8'h4B;
    tx_buf[3] = 8'h12; tx_buf[4] = 8'h34;
    run(5);
    check("R3 capture write 2 bytes", 64'(wd[base % 64]), 64'h1234);
  endtask

  task automatic t_burst_read;
    logic [39:0] e0 = pat(12'h401);
    logic [39:0] e1 = pat(12'h402);
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h04; tx_buf[2] = 8'h01;
    for (int i = 3; i < 13; i++) tx_buf[i] = 8'h00;
    run(13);
    for (int k = 0; k < 5; k++) begin
      check("R7 burst read word0", 64'(rx_buf[3+k]), 64'(e0[(4-k)*8 +: 8]));
      check("R5 burst read word1", 64'(rx_buf[8+k]), 64'(e1[(4-k)*8 +: 8]));
    end
  endtask

  task automatic t_regions;
    int base = wn;
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h0A; tx_buf[2] = 8'h46;
    tx_buf[3] = 8'h0C; tx_buf[4] = 8'h3D;
    run(5);
    check("R3 pointer reg 2 bytes", 64'(wd[base % 64]), 64'h0C3D);
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h0A; tx_buf[2] = 8'h00;
    tx_buf[3] = 8'h91; tx_buf[4] = 8'h92; tx_buf[5] = 8'h93; tx_buf[6] = 8'h94; tx_buf[7] = 8'h95;
    run(8);
    check("R3 wide RAM 5 bytes", 64'(wd[(base+1) % 64]), 64'h9192939495);
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h0A; tx_buf[2] = 8'h60;
    tx_buf[3] = 8'h5A; tx_buf[4] = 8'hC3;
    run(5);
    check("R3 1-byte reg count", 64'(wn - base), 64'd4);
    check("R3 1-byte reg data", 64'(wd[(base+2) % 64]), 64'h5A);
    check("R5 1-byte burst addr", 64'(wa[(base+3) % 64]), 64'hA61);
    check("R5 1-byte burst data", 64'(wd[(base+3) % 64]), 64'hC3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_param_write();
    t_prog_burst();
    t_partial();
    t_nibble();
    t_foreign_chip();
    t_sel_high();
    t_param_read();
    t_capture();
    t_burst_read();
    t_regions();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule